// File: doc/BRIEF.md
# Hidden Command Register Unlock Sequencer

This block hides an 8-bit mode command register behind the palette-mask port of a byte-wide I/O bus. The host reaches it by reading the mask port several times in a row with no other access in between. The reads before the fourth return the ordinary mask value. The fourth read returns an identification byte and turns on a sticky extended-access flag. While the sequence stays at that point, a write to the mask port loads the command register. A fifth read returns the command register and restarts the sequence.

Any access to the read-index, write-index or data port breaks a sequence in progress. So does a write of 0xFF to the mask port, which also withdraws extended access. The upper nibble of the command register is decoded into a pixel-depth code and a pixel-clock divider code, both of which go to the display pipeline. The palette itself, the pixel path and the host bridge sit outside this block.

Top module: `cmd_unlock_seq`

## Requirements
- R1: After a synchronous active-low reset, `cmd_q` is 0x00, `ext_en` is 0, the sequence count is 0, `depth_code` is 0 (8 bpp) and `div_half` is 2.
- R2: The port encoding on `port_sel` is 0 = mask, 1 = read index, 2 = write index, 3 = data. A mask-port read that takes the count to 1, 2 or 3 returns `mask_in` on `rd_data`.
- R3: The mask-port read that takes the count to 4 returns 0x70 and sets `ext_en`, which then stays set until it is cleared as in R6.
- R4: A mask-port write of any value other than 0xFF loads `cmd_q` only while the count is exactly 4. The count is left at 4.
- R5: The mask-port read made while the count is 4 returns the current `cmd_q` and sets the count to 0. `ext_en` is left unchanged.
- R6: A mask-port write of 0xFF sets the count to 0 and clears `ext_en`.
- R7: A mask-port write of a value other than 0xFF while the count is not 4 leaves `cmd_q` and the count unchanged.
- R8: A read or a write of port 1, 2 or 3 sets the count to 0.
- R9: `depth_code` comes from `cmd_q[7:4]`, with codes 0 = 8 bpp, 1 = 15 bpp, 2 = 16 bpp, 3 = 24 bpp and 4 = 32 bpp. Nibbles 2, 3, 8 and A give 1. Nibbles 5, 6 and C give 2. Nibbles 4, 9 and E give 3. Nibble 7 gives 4. Every other nibble gives 0.
- R10: `div_half` is the pixel-clock divider in half units, taken from `cmd_q[7:4]`. Nibble 1 gives 1. Nibble 9 gives 3. Nibbles 2, 6, 7, 8, A and C give 4. Nibbles 4 and E give 6. Nibbles 0, 3 and 5, and every other nibble, give 2.
- R11: `rd_valid` is high for exactly the one cycle after a mask-port read, and `rd_data` is valid in that cycle. Reads of the other ports never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 2 | Decoded port: 0 mask, 1 read index, 2 write index, 3 data |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data byte |
| mask_in | input | 8 | Current palette-mask value, returned by early mask reads |
| rd_valid | output | 1 | Mask-port read data valid |
| rd_data | output | 8 | Mask-port read data |
| ext_en | output | 1 | Sticky extended-access flag |
| cmd_q | output | 8 | Hidden command register |
| depth_code | output | 3 | Pixel-depth code |
| div_half | output | 3 | Clock divider in half units |

## Verification
The bench sweeps all sixteen upper nibbles through a full unlock, load and readback. A wrong decode entry shows up as a depth or divider mismatch, and a lost load shows up as a stale fifth-read value.

It breaks partial sequences with a read and with a write of each of the other three ports, and also with a 0xFF mask write. A design that forgot to restart would return 0x70 too early, or would return the command register where the mask value belongs.

It writes to the mask port at counts below 4 and then finishes the unlock. A design that loaded in that case, or cleared the count, would show the wrong `cmd_q` or would place the identification read at the wrong position.

It also checks that `ext_en` survives the fifth read and that reads of the other ports never raise `rd_valid`.

// File: rtl/ucs_pkg.sv
// Shared types and nibble decode tables for the unlock sequencer.
// Assumes the command register mode field is its upper nibble.
package ucs_pkg;

    typedef enum logic [1:0] {
        PORT_MASK = 2'd0,
        PORT_RIDX = 2'd1,
        PORT_WIDX = 2'd2,
        PORT_DATA = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        DEPTH_8  = 3'd0,
        DEPTH_15 = 3'd1,
        DEPTH_16 = 3'd2,
        DEPTH_24 = 3'd3,
        DEPTH_32 = 3'd4
    } depth_e;

    typedef struct packed {
        logic mask_rd;
        logic mask_wr;
        logic other_acc;
    } bus_ev_t;

    // Pixel depth selected by the mode nibble.
    function automatic depth_e nib_to_depth(input logic [3:0] nib);
        case (nib)
            4'h2, 4'h3, 4'h8, 4'hA: return DEPTH_15;
            4'h5, 4'h6, 4'hC:       return DEPTH_16;
            4'h4, 4'h9, 4'hE:       return DEPTH_24;
            4'h7:                   return DEPTH_32;
            default:                return DEPTH_8;
        endcase
    endfunction

    // Clock divider in half units selected by the mode nibble.
    function automatic logic [2:0] nib_to_div(input logic [3:0] nib);
        case (nib)
            4'h1:                                   return 3'd1;
            4'h9:                                   return 3'd3;
            4'h2, 4'h6, 4'h7, 4'h8, 4'hA, 4'hC:     return 3'd4;
            4'h4, 4'hE:                             return 3'd6;
            default:                                return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/ucs_bus_decode.sv
// Turns the port select and strobes into per-cycle access events.
// Assumes one access per cycle at most; if both strobes are high the read wins.
module ucs_bus_decode
    import ucs_pkg::*;
(
    input  logic [1:0] port_sel,
    input  logic       rd_stb,
    input  logic       wr_stb,
    output bus_ev_t    ev
);

    logic is_mask;
    logic wr_only;

    // Classify the current access.
    always_comb begin
        is_mask      = (port_sel == PORT_MASK);
        wr_only      = wr_stb & ~rd_stb;
        ev.mask_rd   = rd_stb & is_mask;
        ev.mask_wr   = wr_only & is_mask;
        ev.other_acc = (rd_stb | wr_only) & ~is_mask;
    end

endmodule

// File: rtl/ucs_unlock_seq.sv
// Counts back-to-back mask-port reads and holds the sticky extended-access flag.
// Assumes UNLOCK_CNT >= 2; the count never holds a value above UNLOCK_CNT.
module ucs_unlock_seq
    import ucs_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          UNLOCK_CNT = 4,
    parameter logic [7:0]  CLR_BYTE   = 8'hFF,
    localparam int         CW         = $clog2(UNLOCK_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     cnt,
    output logic              ext_en,
    output logic              id_hit,
    output logic              cmd_hit,
    output logic              load_ok
);

    localparam logic [CW-1:0] CNT_ID  = CW'(UNLOCK_CNT - 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(UNLOCK_CNT);

    logic is_clr;

    // Decode which step of the sequence this cycle completes.
    always_comb begin
        is_clr  = (wr_data == DATA_W'(CLR_BYTE));
        id_hit  = ev.mask_rd && (cnt == CNT_ID);
        cmd_hit = ev.mask_rd && (cnt == CNT_TOP);
        load_ok = ev.mask_wr && !is_clr && (cnt == CNT_TOP);
    end

    // Advance, restart or clear the sequence count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ev.mask_rd) begin
            cnt <= cmd_hit ? '0 : cnt + 1'b1;
        end else if ((ev.mask_wr && is_clr) || ev.other_acc) begin
            cnt <= '0;
        end
    end

    // Set the extended-access flag on the identification read; clear it on the clear byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en <= 1'b0;
        end else if (id_hit) begin
            ext_en <= 1'b1;
        end else if (ev.mask_wr && is_clr) begin
            ext_en <= 1'b0;
        end
    end

endmodule

// File: rtl/ucs_cmd_reg.sv
// Holds the command register and registers the mask-port read data.
// Assumes the sequencer raises at most one of id_hit and cmd_hit per cycle.
module ucs_cmd_reg
    import ucs_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  ID_BYTE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              id_hit,
    input  logic              cmd_hit,
    input  logic              load_ok,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mask_in,
    output logic [DATA_W-1:0] cmd_q,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_mux;

    // Pick the byte a mask-port read returns.
    always_comb begin
        if (id_hit)       rd_mux = DATA_W'(ID_BYTE);
        else if (cmd_hit) rd_mux = cmd_q;
        else              rd_mux = mask_in;
    end

    // Load the command register on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (load_ok) cmd_q <= wr_data;
    end

    // Register read data and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= ev.mask_rd;
            if (ev.mask_rd) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/ucs_mode_map.sv
// Decodes the command register mode nibble into pixel depth and clock divider.
// Purely combinational; assumes the mode field is the top nibble of the register.
module ucs_mode_map
    import ucs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cmd_q,
    output logic [2:0]        depth_code,
    output logic [2:0]        div_half
);

    logic [3:0] nib;

    // Look up both mode outputs from the nibble.
    always_comb begin
        nib        = cmd_q[DATA_W-1 -: 4];
        depth_code = nib_to_depth(nib);
        div_half   = nib_to_div(nib);
    end

endmodule

// File: rtl/cmd_unlock_seq.sv
// Top of the hidden command register unlock sequencer.
// Assumes one bus access per cycle, each strobe one cycle wide, on a synchronous bus.
module cmd_unlock_seq
    import ucs_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter int          UNLOCK_CNT = 4,
    parameter logic [7:0]  ID_BYTE    = 8'h70,
    parameter logic [7:0]  CLR_BYTE   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] mask_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ext_en,
    output logic [DATA_W-1:0] cmd_q,
    output logic [2:0]        depth_code,
    output logic [2:0]        div_half
);

    localparam int CW = $clog2(UNLOCK_CNT + 1);

    bus_ev_t       ev;
    logic [CW-1:0] seq_cnt;
    logic          id_hit;
    logic          cmd_hit;
    logic          load_ok;

    ucs_bus_decode u_dec (
        .port_sel (port_sel),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .ev       (ev)
    );

    ucs_unlock_seq #(
        .DATA_W     (DATA_W),
        .UNLOCK_CNT (UNLOCK_CNT),
        .CLR_BYTE   (CLR_BYTE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .wr_data (wr_data),
        .cnt     (seq_cnt),
        .ext_en  (ext_en),
        .id_hit  (id_hit),
        .cmd_hit (cmd_hit),
        .load_ok (load_ok)
    );

    ucs_cmd_reg #(
        .DATA_W  (DATA_W),
        .ID_BYTE (ID_BYTE)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .id_hit   (id_hit),
        .cmd_hit  (cmd_hit),
        .load_ok  (load_ok),
        .wr_data  (wr_data),
        .mask_in  (mask_in),
        .cmd_q    (cmd_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    ucs_mode_map #(
        .DATA_W (DATA_W)
    ) u_map (
        .cmd_q      (cmd_q),
        .depth_code (depth_code),
        .div_half   (div_half)
    );

endmodule

// File: rtl/cmd_unlock_seq_chk.sv
// Checker for the unlock sequencer, bound to the top module.
// Observes ports plus the internal sequence count.
module cmd_unlock_seq_chk #(
    parameter int          DATA_W     = 8,
    parameter int          UNLOCK_CNT = 4,
    parameter logic [7:0]  ID_BYTE    = 8'h70,
    parameter logic [7:0]  CLR_BYTE   = 8'hFF,
    localparam int         CW         = $clog2(UNLOCK_CNT + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        port_sel,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              ext_en,
    input logic [DATA_W-1:0] cmd_q,
    input logic [CW-1:0]     cnt
);

    logic m_rd, m_wr, o_acc;
    assign m_rd  = rd_stb && port_sel == 2'd0;
    assign m_wr  = wr_stb && !rd_stb && port_sel == 2'd0;
    assign o_acc = (rd_stb || wr_stb) && port_sel != 2'd0;

    assert_id_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd && cnt == CW'(UNLOCK_CNT - 1) |=> rd_valid && rd_data == DATA_W'(ID_BYTE) && ext_en);

    assert_cmd_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd && cnt == CW'(UNLOCK_CNT) |=> rd_data == $past(cmd_q) && cnt == '0 && ext_en == $past(ext_en));

    assert_clear_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr && wr_data == DATA_W'(CLR_BYTE) |=> cnt == '0 && !ext_en);

    assert_other_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_acc |=> cnt == '0);

    assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr && wr_data != DATA_W'(CLR_BYTE) && cnt != CW'(UNLOCK_CNT) |=> $stable(cmd_q) && $stable(cnt));

    assert_load_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr && wr_data != DATA_W'(CLR_BYTE) && cnt == CW'(UNLOCK_CNT) |=> cmd_q == $past(wr_data) && cnt == CW'(UNLOCK_CNT));

    assert_ext_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_en) |-> $past(m_rd && cnt == CW'(UNLOCK_CNT - 1)));

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(m_rd));

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(UNLOCK_CNT));

endmodule

bind cmd_unlock_seq cmd_unlock_seq_chk #(
    .DATA_W     (DATA_W),
    .UNLOCK_CNT (UNLOCK_CNT),
    .ID_BYTE    (ID_BYTE),
    .CLR_BYTE   (CLR_BYTE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_sel (port_sel),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .ext_en   (ext_en),
    .cmd_q    (cmd_q),
    .cnt      (seq_cnt)
);

// File: tb/cmd_unlock_seq_bench.sv
// Self-checking bench for the unlock sequencer: directed corners plus a full nibble sweep.
module cmd_unlock_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_sel = 2'd0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] mask_in = 8'hFF;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       ext_en;
    logic [7:0] cmd_q;
    logic [2:0] depth_code;
    logic [2:0] div_half;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got;
    logic       gotv;

    always #4 clk = ~clk;

    cmd_unlock_seq u_cmd_unlock_seq (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wr_data(wr_data), .mask_in(mask_in),
        .rd_valid(rd_valid), .rd_data(rd_data), .ext_en(ext_en),
        .cmd_q(cmd_q), .depth_code(depth_code), .div_half(div_half)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_port(input logic [1:0] p);
        @(negedge clk);
        port_sel = p; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        got  = rd_data;
        gotv = rd_valid;
    endtask

    task automatic wr_port(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        port_sel = p; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    function automatic logic [2:0] exp_depth(input logic [3:0] n);
        if (n == 4'h7) return 3'd4;
        if (n == 4'h4 || n == 4'h9 || n == 4'hE) return 3'd3;
        if (n == 4'h5 || n == 4'h6 || n == 4'hC) return 3'd2;
        if (n == 4'h2 || n == 4'h3 || n == 4'h8 || n == 4'hA) return 3'd1;
        return 3'd0;
    endfunction

    function automatic logic [2:0] exp_div(input logic [3:0] n);
        if (n == 4'h1) return 3'd1;
        if (n == 4'h9) return 3'd3;
        if (n == 4'h4 || n == 4'hE) return 3'd6;
        if (n == 4'h2 || n == 4'h6 || n == 4'h7 || n == 4'h8 || n == 4'hA || n == 4'hC) return 3'd4;
        return 3'd2;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", cmd_q, 8'h00);
        chk("R1 ext", {7'd0, ext_en}, 8'h00);
        chk("R1 depth", {5'd0, depth_code}, 8'h00);
        chk("R1 div", {5'd0, div_half}, 8'h02);
        chk("R11 idle valid", {7'd0, rd_valid}, 8'h00);

        // R2 pass-through, R3 id, R4 load, R5 readback
        mask_in = 8'hFF;
        for (int i = 0; i < 3; i++) begin
            rd_port(2'd0);
            chk("R2 pass", got, 8'hFF);
            chk("R11 valid", {7'd0, gotv}, 8'h01);
        end
        @(negedge clk);
        chk("R11 valid drops", {7'd0, rd_valid}, 8'h00);
        rd_port(2'd0);
        chk("R3 id", got, 8'h70);
        chk("R3 ext", {7'd0, ext_en}, 8'h01);
        wr_port(2'd0, 8'h5A);
        chk("R4 load", cmd_q, 8'h5A);
        rd_port(2'd0);
        chk("R5 readback", got, 8'h5A);
        chk("R5 ext kept", {7'd0, ext_en}, 8'h01);
        mask_in = 8'h3C;
        rd_port(2'd0);
        chk("R5 count restarted", got, 8'h3C);

        // R6 clear byte
        wr_port(2'd0, 8'hFF);
        chk("R6 ext cleared", {7'd0, ext_en}, 8'h00);
        for (int i = 0; i < 4; i++) rd_port(2'd0);
        chk("R3 id again", got, 8'h70);
        wr_port(2'd0, 8'hFF);
        chk("R6 ext cleared at 4", {7'd0, ext_en}, 8'h00);
        rd_port(2'd0);
        chk("R6 count cleared", got, 8'h3C);
        wr_port(2'd1, 8'h00);

        // R7 ignored write keeps count and command
        rd_port(2'd0); rd_port(2'd0);
        wr_port(2'd0, 8'h11);
        chk("R7 cmd kept", cmd_q, 8'h5A);
        rd_port(2'd0);
        chk("R7 third pass", got, 8'h3C);
        rd_port(2'd0);
        chk("R7 count kept", got, 8'h70);
        rd_port(2'd0);
        chk("R7 cmd via read", got, 8'h5A);

        // R8 other-port access breaks the sequence, R11 no valid for other ports
        for (int p = 1; p < 4; p++) begin
            for (int w = 0; w < 2; w++) begin
                rd_port(2'd0); rd_port(2'd0); rd_port(2'd0);
                if (w == 1) wr_port(2'(p), 8'h00);
                else begin
                    rd_port(2'(p));
                    chk("R11 other port valid", {7'd0, gotv}, 8'h00);
                end
                for (int k = 0; k < 3; k++) begin
                    rd_port(2'd0);
                    chk("R8 restart pass", got, 8'h3C);
                end
                rd_port(2'd0);
                chk("R8 id after restart", got, 8'h70);
                wr_port(2'd2, 8'h00);
            end
        end

        // R9 R10 full nibble sweep with R4 R5 readback
        for (int n = 0; n < 16; n++) begin
            prev = {4'(n), 4'(~n)};
            if (prev == 8'hFF) prev = 8'hF0;
            wr_port(2'd1, 8'h00);
            for (int k = 0; k < 4; k++) rd_port(2'd0);
            wr_port(2'd0, prev);
            chk("R9 depth", {5'd0, depth_code}, {5'd0, exp_depth(4'(n))});
            chk("R10 div", {5'd0, div_half}, {5'd0, exp_div(4'(n))});
            rd_port(2'd0);
            chk("R5 sweep readback", got, prev);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule